// File: doc/BRIEF.md
# Exception Entry Unit with Mode-Banked Registers

This block performs the processor state change that happens when an exception is accepted. Four request lines are presented in the same cycle: privileged call, instruction trap, data trap and interrupt. Alongside them come the current program counter, the current status word and a control bit that moves the vector table to the top of the address space. A fixed priority picks one request. The block then completes the whole entry in one clock edge. It swaps the banked registers, saves the status word, captures the return address, computes the new status and the vector address, and pulses a flush towards the fetch stage.

The block holds the live copies of r29, r30 and the saved-status register (bsr), together with five banks that six processor modes share. It also has a simple write port, so the surrounding pipeline can update the live copies between exceptions. The mode field is status bits [4:0] and the interrupt-disable flag is status bit 7. The mode encodings are: user 0x10, super-user 0x1F, privileged 0x13, trap 0x17, extension 0x1B and interrupt 0x12. Any other value of the current mode field has no bank.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, pc_out, stat_out, r29_out, r30_out, bsr_out, flush and mode_err are all zero.
- R2: The vector offset and the mode entered are fixed per request: data trap gives 0x10 and trap mode; instruction trap gives 0x0C and trap mode; interrupt gives 0x18 and interrupt mode; privileged call (req bit 0) gives 0x08 and privileged mode. The request bits are: bit 2 data trap, bit 1 instruction trap, bit 3 interrupt, bit 0 privileged call. The result shows on pc_out and on stat_out[4:0] after the next rising edge.
- R3: When hi_vec is 1 at the request, pc_out is 0xFFFF0000 plus the vector offset.
- R4: When several requests are present at once, the priority is data trap, then instruction trap, then interrupt, then privileged call.
- R5: On entry, bsr_out becomes the full incoming status word. stat_out becomes the incoming status word with bits [4:0] replaced by the new mode and bit 7 set.
- R6: On entry, r30_out becomes pc_in, and flush is 1 for exactly the cycle after each accepted request edge.
- R7: On entry with a mode change, the live r29 (with r30 and bsr) is stored into the bank of the old mode, and r29_out is loaded from the bank of the new mode. The banks are: user and super-user share bank 0, privileged uses 1, trap uses 2, extension uses 3 and interrupt uses 4. All banks reset to zero.
- R8: On entry where the new mode equals the current mode, no bank swap occurs and r29_out keeps its value.
- R9: A request while stat_in[4:0] holds a mode with no bank pulses mode_err for one cycle. It raises no flush and leaves pc_out, stat_out, r29_out, r30_out, bsr_out and the banks unchanged.
- R10: With no request, wr_en writes wr_data into the live r29, r30 or bsr for wr_sel 0, 1 or 2; wr_sel 3 writes nothing. While any request is present, the write is ignored.
- R11: The super-user mode is accepted as a current mode (bank 0) without raising mode_err.
- R12: With no request and no write, all outputs hold and flush and mode_err stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Requests: bit0 privileged call, bit1 instruction trap, bit2 data trap, bit3 interrupt |
| pc_in | input | 32 | Current program counter (becomes the return address) |
| stat_in | input | 32 | Current status word; bits [4:0] are the mode |
| hi_vec | input | 1 | High vector table select |
| wr_en | input | 1 | Write enable for the live registers |
| wr_sel | input | 2 | Write target: 0 r29, 1 r30, 2 bsr, 3 none |
| wr_data | input | 32 | Write data |
| pc_out | output | 32 | Vector address of the last entry |
| stat_out | output | 32 | Status word after the last entry |
| r29_out | output | 32 | Live r29 |
| r30_out | output | 32 | Live r30 (link) |
| bsr_out | output | 32 | Live saved-status register |
| flush | output | 1 | One-cycle pulse telling fetch to discard in-flight instructions |
| mode_err | output | 1 | One-cycle pulse for a request made in an unbanked mode |

## Verification
A bank written to the wrong index, or a swap skipped, stays hidden until a later exception returns to that mode. It then shows as a wrong r29_out one cycle after that later entry edge. For that reason the sequence walks trap, privileged and trap again, and it includes a same-mode entry that would expose a spurious swap. The priority, the vector, the status merge and the return-address capture all show on pc_out, stat_out and r30_out one edge after the request. An unbanked mode is caught by checking mode_err, together with every output holding in that same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int MODE_W = 5;
   typedef logic [MODE_W-1:0] mode_t;

   localparam mode_t M_USER = 5'h10;
   localparam mode_t M_SUSR = 5'h1F;
   localparam mode_t M_PRIV = 5'h13;
   localparam mode_t M_TRAP = 5'h17;
   localparam mode_t M_EXTN = 5'h1B;
   localparam mode_t M_INTR = 5'h12;

   localparam int NREQ      = 4;
   localparam int REQ_PRIV  = 0;
   localparam int REQ_ITRAP = 1;
   localparam int REQ_DTRAP = 2;
   localparam int REQ_INTR  = 3;

   localparam logic [7:0] OFF_PRIV  = 8'h08;
   localparam logic [7:0] OFF_ITRAP = 8'h0C;
   localparam logic [7:0] OFF_DTRAP = 8'h10;
   localparam logic [7:0] OFF_INTR  = 8'h18;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic [NREQ-1:0] req,
   output logic            any,
   output mode_t           new_mode,
   output logic [7:0]      offset
);
   localparam int PRIO [NREQ] = '{REQ_DTRAP, REQ_ITRAP, REQ_INTR, REQ_PRIV};

   logic [NREQ-1:0] grant;

   always_comb begin
      grant = '0;
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (req[PRIO[i]]) begin
            grant = '0;
            grant[PRIO[i]] = 1'b1;
         end
      end
   end

   always_comb begin
      any      = |req;
      new_mode = M_PRIV;
      offset   = OFF_PRIV;
      if (grant[REQ_DTRAP]) begin
         new_mode = M_TRAP;
         offset   = OFF_DTRAP;
      end else if (grant[REQ_ITRAP]) begin
         new_mode = M_TRAP;
         offset   = OFF_ITRAP;
      end else if (grant[REQ_INTR]) begin
         new_mode = M_INTR;
         offset   = OFF_INTR;
      end
   end
endmodule

// File: rtl/exc_bank_map.sv
module exc_bank_map
   import exc_pkg::*;
#(
   parameter int NBANK  = 5,
   localparam int BIDX_W = $clog2(NBANK)
)(
   input  mode_t             mode,
   output logic [BIDX_W-1:0] idx,
   output logic              valid
);
   always_comb begin
      valid = 1'b1;
      idx   = '0;
      case (mode)
         M_USER, M_SUSR: idx = BIDX_W'(0);
         M_PRIV:         idx = BIDX_W'(1);
         M_TRAP:         idx = BIDX_W'(2);
         M_EXTN:         idx = BIDX_W'(3);
         M_INTR:         idx = BIDX_W'(4);
         default:        valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file #(
   parameter int XLEN   = 32,
   parameter int NBANK  = 5,
   localparam int BIDX_W = $clog2(NBANK)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BIDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]   wr_r29,
   input  logic [XLEN-1:0]   wr_r30,
   input  logic [XLEN-1:0]   wr_bsr,
   input  logic [BIDX_W-1:0] rd_idx,
   output logic [XLEN-1:0]   rd_r29,
   output logic [XLEN-1:0]   rd_r30,
   output logic [XLEN-1:0]   rd_bsr
);
   logic [XLEN-1:0] r29_q [NBANK];
   logic [XLEN-1:0] r30_q [NBANK];
   logic [XLEN-1:0] bsr_q [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r29_q[g] <= '0;
            r30_q[g] <= '0;
            bsr_q[g] <= '0;
         end else if (we && wr_idx == BIDX_W'(g)) begin
            r29_q[g] <= wr_r29;
            r30_q[g] <= wr_r30;
            bsr_q[g] <= wr_bsr;
         end
      end
   end

   always_comb begin
      rd_r29 = '0;
      rd_r30 = '0;
      rd_bsr = '0;
      for (int i = 0; i < NBANK; i++) begin
         if (rd_idx == BIDX_W'(i)) begin
            rd_r29 = r29_q[i];
            rd_r30 = r30_q[i];
            rd_bsr = bsr_q[i];
         end
      end
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              NBANK      = 5,
   parameter int              IDIS_BIT   = 7,
   parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      req,
   input  logic [XLEN-1:0] pc_in,
   input  logic [XLEN-1:0] stat_in,
   input  logic            hi_vec,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] pc_out,
   output logic [XLEN-1:0] stat_out,
   output logic [XLEN-1:0] r29_out,
   output logic [XLEN-1:0] r30_out,
   output logic [XLEN-1:0] bsr_out,
   output logic            flush,
   output logic            mode_err
);
   localparam int BIDX_W = $clog2(NBANK);

   if (XLEN < 32) begin : g_chk_xlen
      $error("exc_entry_unit: XLEN must be at least 32");
   end
   if (NBANK < 5) begin : g_chk_bank
      $error("exc_entry_unit: five banks are required");
   end
   if (IDIS_BIT < MODE_W || IDIS_BIT >= XLEN) begin : g_chk_idis
      $error("exc_entry_unit: interrupt-disable bit overlaps mode field");
   end

   logic              any_req;
   mode_t             new_mode;
   logic [7:0]        vec_off;
   mode_t             old_mode;
   logic [BIDX_W-1:0] old_idx, new_idx;
   logic              old_ok, new_ok;
   logic              take, bad, swap;
   logic [XLEN-1:0]   ld_r29, ld_r30, ld_bsr;
   logic [XLEN-1:0]   vec_addr, stat_new;

   logic [XLEN-1:0]   pc_q, stat_q, r29_q, r30_q, bsr_q;
   logic              flush_q, err_q;

   assign old_mode = stat_in[MODE_W-1:0];

   exc_arbiter u_arb (
      .req      (req),
      .any      (any_req),
      .new_mode (new_mode),
      .offset   (vec_off)
   );

   exc_bank_map #(.NBANK(NBANK)) u_map_old (
      .mode  (old_mode),
      .idx   (old_idx),
      .valid (old_ok)
   );

   exc_bank_map #(.NBANK(NBANK)) u_map_new (
      .mode  (new_mode),
      .idx   (new_idx),
      .valid (new_ok)
   );

   assign take = any_req && old_ok;
   assign bad  = any_req && !old_ok;
   assign swap = take && (old_mode != new_mode);

   exc_bank_file #(.XLEN(XLEN), .NBANK(NBANK)) u_banks (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (swap),
      .wr_idx (old_idx),
      .wr_r29 (r29_q),
      .wr_r30 (r30_q),
      .wr_bsr (bsr_q),
      .rd_idx (new_idx),
      .rd_r29 (ld_r29),
      .rd_r30 (ld_r30),
      .rd_bsr (ld_bsr)
   );

   // r30 and bsr are reloaded then overwritten in the same entry
   logic unused_bank_read;
   assign unused_bank_read = ^{ld_r30, ld_bsr, new_ok};

   assign vec_addr = (hi_vec ? HIVEC_BASE : '0) + XLEN'(vec_off);

   always_comb begin
      stat_new = stat_in;
      stat_new[MODE_W-1:0] = new_mode;
      stat_new[IDIS_BIT]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= '0;
         stat_q  <= '0;
         r29_q   <= '0;
         r30_q   <= '0;
         bsr_q   <= '0;
         flush_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         flush_q <= take;
         err_q   <= bad;
         if (take) begin
            pc_q   <= vec_addr;
            stat_q <= stat_new;
            r30_q  <= pc_in;
            bsr_q  <= stat_in;
            if (swap) r29_q <= ld_r29;
         end else if (!any_req && wr_en) begin
            case (wr_sel)
               2'd0:    r29_q <= wr_data;
               2'd1:    r30_q <= wr_data;
               2'd2:    bsr_q <= wr_data;
               default: ;
            endcase
         end
      end
   end

   assign pc_out   = pc_q;
   assign stat_out = stat_q;
   assign r29_out  = r29_q;
   assign r30_out  = r30_q;
   assign bsr_out  = bsr_q;
   assign flush    = flush_q;
   assign mode_err = err_q;

   assert_vec_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> (pc_q[7:0] == OFF_PRIV || pc_q[7:0] == OFF_ITRAP ||
                   pc_q[7:0] == OFF_DTRAP || pc_q[7:0] == OFF_INTR));

   assert_idis_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> stat_q[IDIS_BIT]);

   assert_ret_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> (r30_q == $past(pc_in)));

   assert_err_no_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !flush_q);

   assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> ($stable(pc_q) && $stable(stat_q) && $stable(r29_q)));
endmodule

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;
   localparam logic [4:0] USR = 5'h10, SUS = 5'h1F, PRV = 5'h13,
                          TRP = 5'h17, EXT = 5'h1B, INT = 5'h12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req = '0;
   logic [31:0] pc_in = '0, stat_in = '0, wr_data = '0;
   logic        hi_vec = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] pc_out, stat_out, r29_out, r30_out, bsr_out;
   logic        flush, mode_err;

   always #4 clk = ~clk;

   exc_entry_unit dut (
      .clk(clk), .rst_n(rst_n), .req(req), .pc_in(pc_in), .stat_in(stat_in),
      .hi_vec(hi_vec), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pc_out(pc_out), .stat_out(stat_out), .r29_out(r29_out),
      .r30_out(r30_out), .bsr_out(bsr_out), .flush(flush), .mode_err(mode_err)
   );

   typedef struct {
      string       tag;
      logic [31:0] pc, st, r29, r30, bsr;
      logic        fl, er;
   } item_t;

   item_t       sb[$];
   int          total = 0, bad = 0;
   bit          done = 0;

   logic [31:0] m_pc = '0, m_st = '0, m29 = '0, m30 = '0, mbsr = '0;
   logic [31:0] bk29 [5];

   function automatic int bank_of(input logic [4:0] m);
      case (m)
         USR, SUS: return 0;
         PRV:      return 1;
         TRP:      return 2;
         EXT:      return 3;
         INT:      return 4;
         default:  return -1;
      endcase
   endfunction

   function automatic logic [31:0] st_word(input logic [31:0] base, input logic [4:0] m);
      return (base & ~32'h0000_009F) | {27'd0, m};
   endfunction

   task automatic step(input logic [3:0] rq, input logic [31:0] pcv, stv,
                       input logic hv, we, input logic [1:0] ws,
                       input logic [31:0] wd, input string tag);
      item_t e;
      logic [4:0] om, nm;
      logic [7:0] off;
      int ob, nb;
      @(negedge clk);
      req = rq; pc_in = pcv; stat_in = stv; hi_vec = hv;
      wr_en = we; wr_sel = ws; wr_data = wd;
      e.fl = 1'b0; e.er = 1'b0;
      om = stv[4:0];
      if (rq != 4'd0) begin
         if (rq[2])      begin nm = TRP; off = 8'h10; end
         else if (rq[1]) begin nm = TRP; off = 8'h0C; end
         else if (rq[3]) begin nm = INT; off = 8'h18; end
         else            begin nm = PRV; off = 8'h08; end
         ob = bank_of(om);
         if (ob < 0) e.er = 1'b1;
         else begin
            if (om != nm) begin
               nb = bank_of(nm);
               bk29[ob] = m29;
               m29 = bk29[nb];
            end
            mbsr = stv;
            m30  = pcv;
            m_st = (stv & ~32'h1F) | {27'd0, nm} | 32'h80;
            m_pc = {24'd0, off} + (hv ? 32'hFFFF_0000 : 32'd0);
            e.fl = 1'b1;
         end
      end else if (we) begin
         case (ws)
            2'd0: m29 = wd;
            2'd1: m30 = wd;
            2'd2: mbsr = wd;
            default: ;
         endcase
      end
      e.tag = tag; e.pc = m_pc; e.st = m_st; e.r29 = m29; e.r30 = m30; e.bsr = mbsr;
      sb.push_back(e);
   endtask

   task automatic chk(input string tag, input string f, input logic [31:0] a, x);
      total++;
      if (a !== x) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, f, a, x);
      end
   endtask

   initial begin : monitor
      item_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(e.tag, "pc_out",   pc_out,   e.pc);
            chk(e.tag, "stat_out", stat_out, e.st);
            chk(e.tag, "r29_out",  r29_out,  e.r29);
            chk(e.tag, "r30_out",  r30_out,  e.r30);
            chk(e.tag, "bsr_out",  bsr_out,  e.bsr);
            chk(e.tag, "flush",    {31'd0, flush},    {31'd0, e.fl});
            chk(e.tag, "mode_err", {31'd0, mode_err}, {31'd0, e.er});
         end
      end
   end

   initial begin : watchdog
      #200000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      for (int i = 0; i < 5; i++) bk29[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(4'b0000, 0, st_word(32'h0, USR), 0, 0, 0, 0, "R1 reset");
      step(4'b0000, 0, st_word(32'h0, USR), 0, 1, 2'd0, 32'h1111_1111, "R10 wr r29");
      step(4'b0000, 0, st_word(32'h0, USR), 0, 1, 2'd1, 32'h2222_2222, "R10 wr r30");
      step(4'b0000, 0, st_word(32'h0, USR), 0, 1, 2'd2, 32'h3333_3333, "R10 wr bsr");
      step(4'b0000, 0, st_word(32'h0, USR), 0, 1, 2'd3, 32'h4444_4444, "R10 sel3");
      step(4'b0000, 0, st_word(32'h0, USR), 0, 0, 0, 0, "R12 idle");
      step(4'b0100, 32'h0000_1000, st_word(32'h5A5A_5A00, USR), 0, 0, 0, 0, "R2 R5 R7 dtrap");
      step(4'b0000, 0, 0, 0, 1, 2'd0, 32'h0000_BEEF, "R10 wr trap r29");
      step(4'b0001, 32'h0000_2004, st_word(32'hC3C3_0000, TRP), 1, 0, 0, 0, "R3 R7 privcall hi");
      step(4'b0000, 0, 0, 0, 1, 2'd0, 32'h0000_CAFE, "R10 wr priv r29");
      step(4'b0010, 32'h0000_3008, st_word(32'h0F0F_0F00, PRV), 0, 0, 0, 0, "R2 R7 itrap restore");
      step(4'b0000, 0, 0, 0, 1, 2'd0, 32'h0000_7777, "R10 wr r29 again");
      step(4'b0010, 32'h0000_400C, st_word(32'h1234_5600, TRP), 0, 0, 0, 0, "R8 same mode");
      step(4'b1000, 32'h0000_5010, st_word(32'hFFFF_FF00, SUS), 1, 0, 0, 0, "R2 R3 R11 intr from susr");
      step(4'b1111, 32'h0000_6000, st_word(32'h0, INT), 0, 0, 0, 0, "R4 all four");
      step(4'b1011, 32'h0000_6100, st_word(32'h0, TRP), 0, 0, 0, 0, "R4 no dtrap");
      step(4'b1001, 32'h0000_6200, st_word(32'h0, TRP), 0, 0, 0, 0, "R4 intr over priv");
      step(4'b0001, 32'h0000_6300, st_word(32'h0, EXT), 0, 0, 0, 0, "R2 R7 priv from ext");
      step(4'b0100, 32'h0000_7000, st_word(32'hAAAA_0000, 5'h00), 1, 1, 2'd0, 32'h0000_DEAD, "R9 bad mode");
      step(4'b0000, 0, 0, 0, 0, 0, 0, "R12 after err");
      step(4'b0010, 32'h0000_8000, st_word(32'h0, PRV), 0, 1, 2'd1, 32'h0000_F00D, "R10 write ignored");
      step(4'b0000, 0, 0, 0, 0, 0, 0, "R6 R12 flush drop");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule